// File: doc/BRIEF.md
# One-Shot Match Tick Timer

This block is a memory-mapped tick timer for an operating system. It keeps a 32-bit counter value and one match value. A write to the match location starts a single countdown. Its length is the distance from the counter value, captured at reset or at the last expiry, to the new match value, and it wraps around through the top of the 32-bit range when the match value is not above the counter. The countdown moves one step for each clock cycle in which the tick-enable input is high. The integration drives that input at the timer's nominal 50 MHz rate, relative to the system clock.

When the countdown runs out, the counter takes the match value and the timer stops. It starts again only on the next write to the match location. If the interrupt-enable word holds a nonzero value at that moment, a sticky status bit is set, and the interrupt output follows that bit as a level. Software clears the status bit, and the interrupt with it, by writing the status location. Reads of the counter location return the match value minus the countdown's remaining length. All accesses are full 32-bit words on a simple bus with address, write strobe, write data and combinational read data.

Top module: `ostick_timer`

## Requirements
- R1: After reset the counter (address 0x10), status (0x14) and interrupt-enable (0x1C) locations all read 0, and `irq` is low.
- R2: A write to address 0x00 stores the match value M and arms a countdown. If M is greater than the captured counter C, the length is M-C. Otherwise the length is M+(0xFFFFFFFF-C), taken modulo 2^32. C is 0 after reset and is updated only at expiry.
- R3: While the countdown is armed, each cycle with `tick_en` high lowers the remaining length by one. Address 0x10 always reads M minus the remaining length, modulo 2^32.
- R4: The countdown expires on the tick that takes the remaining length to zero. After that, address 0x10 reads M and stays unchanged under further ticks until the next write to address 0x00.
- R5: If the interrupt-enable word is nonzero at expiry, status bit 0 (address 0x14) reads 1 and `irq` is high from the cycle after the expiring tick. If the word is zero, both stay 0.
- R6: A write of any data to address 0x14 clears the status bit and `irq` on the next cycle.
- R7: Address 0x1C stores and returns all 32 written bits. Expiry uses the value held before the edge.
- R8: Reads of address 0x00 and of every unmapped address return 0. Writes to unmapped addresses change no readable state and no `irq`.
- R9: When a match write and an expiring tick fall in the same cycle, the write wins. The countdown re-arms from the old captured counter, and no status or interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the word access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| tick_en | input | 1 | Countdown step enable |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt level, equal to the status bit |

## Verification
A remaining length that is wrong by even one step shows at once in the counter read, because that read is the match value minus the remaining length. The bench therefore compares it after every cycle of each sweep. A captured counter that fails to update at expiry stays hidden until the next match write, and then shows as a wrong counter read one cycle later, since the countdown length is built from that captured value. A bad status path shows on `irq` and on the status read on the cycle after the expiring tick or the clearing write. The bench checks every such cycle, both with interrupts enabled and with them disabled.

// File: rtl/ostick_pkg.sv
package ostick_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MATCH  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_IEN
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MATCH:  return SEL_MATCH;
            OFS_COUNT:  return SEL_COUNT;
            OFS_STATUS: return SEL_STATUS;
            OFS_IEN:    return SEL_IEN;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ostick_countdown.sv
module ostick_countdown #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_len,
    input  logic          tick_en,
    output logic [DW-1:0] remaining,
    output logic          expire
);

    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic [DW-1:0] rem;
        logic          armed;
    } cd_t;

    cd_t st_d, st_q;
    logic last_step;

    // a zero length counts as already at its last step
    assign last_step = st_q.armed && tick_en && (st_q.rem <= ONE);
    // a match write in the same cycle wins over the expiry
    assign expire    = last_step && !load;
    assign remaining = st_q.rem;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.rem   = load_len;
            st_d.armed = 1'b1;
        end else if (last_step) begin
            st_d.rem   = '0;
            st_d.armed = 1'b0;
        end else if (st_q.armed && tick_en) begin
            st_d.rem = st_q.rem - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && tick_en && !load && st_q.rem > ONE)
            |=> (st_q.rem == $past(st_q.rem) - ONE));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !load) |=> $stable(st_q.rem));

    assert_expire_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!st_q.armed && st_q.rem == '0));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.armed && st_q.rem == $past(load_len)));

endmodule

// File: rtl/ostick_regs.sv
module ostick_regs
    import ostick_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic              expire,
    input  logic [DW-1:0]     remaining,
    output logic              load,
    output logic [DW-1:0]     load_len,
    output logic [DW-1:0]     rdata,
    output logic              irq
);

    typedef struct packed {
        logic [DW-1:0] match;
        logic [DW-1:0] base;
        logic [DW-1:0] ien;
        logic          stat;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic     wr_status, wr_ien;

    assign sel       = decode_addr(addr);
    assign load      = wr_en && (sel == SEL_MATCH);
    assign wr_status = wr_en && (sel == SEL_STATUS);
    assign wr_ien    = wr_en && (sel == SEL_IEN);

    // distance from captured counter to new match, wrapping through all-ones
    assign load_len = (wdata > r_q.base) ? (wdata - r_q.base)
                                         : (wdata + ('1 - r_q.base));

    always_comb begin
        r_d = r_q;
        if (load)   r_d.match = wdata;
        if (expire) r_d.base  = r_q.match;
        if (wr_ien) r_d.ien   = wdata;
        if (wr_status) r_d.stat = 1'b0;
        // a new expiry event is not lost to a clear in the same cycle
        if (expire && (r_q.ien != '0)) r_d.stat = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel)
            SEL_COUNT:  rdata = r_q.match - remaining;
            SEL_STATUS: rdata = {{(DW-1){1'b0}}, r_q.stat};
            SEL_IEN:    rdata = r_q.ien;
            default:    rdata = '0;
        endcase
    end

    assign irq = r_q.stat;

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.stat) |-> ($past(expire) && ($past(r_q.ien) != '0)));

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.stat) |-> $past(wr_status));

    assert_snap_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (r_q.base == $past(r_q.match)));

    assert_no_irq_on_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !r_q.stat) |=> !r_q.stat);

endmodule

// File: rtl/ostick_timer.sv
module ostick_timer
    import ostick_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic              tick_en,
    output logic [DW-1:0]     rdata,
    output logic              irq
);

    logic          load;
    logic          expire;
    logic [DW-1:0] load_len;
    logic [DW-1:0] remaining;

    ostick_countdown #(.DW(DW)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_len  (load_len),
        .tick_en   (tick_en),
        .remaining (remaining),
        .expire    (expire)
    );

    ostick_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .expire    (expire),
        .remaining (remaining),
        .load      (load),
        .load_len  (load_len),
        .rdata     (rdata),
        .irq       (irq)
    );

endmodule

// File: tb/sim_ostick_timer.sv
module sim_ostick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        tick_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_match = '0, m_base = '0, m_rem = '0, m_ien = '0;
    logic        m_armed = 1'b0, m_stat = 1'b0;

    always #4 clk = ~clk;

    ostick_timer u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .tick_en(tick_en), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    // one clock cycle of stimulus; the model follows the requirements
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic t);
        logic last, ld, ex;
        wr_en = w; addr = a; wdata = d; tick_en = t;
        @(posedge clk);
        last = m_armed && t && (m_rem <= 32'd1);
        ld   = w && (a == 8'h00);
        ex   = last && !ld;
        if (w && a == 8'h14) m_stat = 1'b0;
        if (ex && m_ien != 0) m_stat = 1'b1;
        if (ld) begin
            m_rem   = (d > m_base) ? d - m_base : d + (32'hFFFF_FFFF - m_base);
            m_match = d;
            m_armed = 1'b1;
        end else if (ex) begin
            m_rem   = '0;
            m_armed = 1'b0;
            m_base  = m_match;
        end else if (m_armed && t) begin
            m_rem = m_rem - 1;
        end
        if (w && a == 8'h1C) m_ien = d;
        #1;
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(8'h10, v); chk({tag, " counter"}, v, m_match - m_rem);
        rd(8'h14, v); chk({tag, " status"}, v, {31'd0, m_stat});
        rd(8'h1C, v); chk({tag, " ien"}, v, m_ien);
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_stat});
    endtask

    task automatic run_out(input int sp, input string tag);
        int cyc = 0;
        while (m_armed && cyc < 2000) begin
            step(1'b0, 8'h08, '0, (cyc % sp) == 0);
            check_all(tag);
            cyc++;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] b;
        int lens [5] = '{1, 2, 3, 7, 20};

        repeat (2) @(posedge clk);
        #4;
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check_all("R1");
        rd(8'h00, v); chk("R1 match read", v, 32'd0);

        // R7: enable word round trip
        step(1'b1, 8'h1C, 32'hA5A5_0001, 1'b0);
        check_all("R7");

        // R2 R3 R4 R5 R6: sweep lengths and tick spacings
        for (int sp = 1; sp <= 3; sp++) begin
            foreach (lens[i]) begin
                step(1'b1, 8'h1C, ((i + sp) % 2 == 0) ? 32'd0 : 32'h0000_0100, 1'b0);
                step(1'b1, 8'h00, m_base + lens[i], 1'b0);
                check_all("R2");
                run_out(sp, "R3");
                rd(8'h10, v); chk("R4 snap", v, m_match);
                chk("R5 irq", {31'd0, irq}, {31'd0, m_ien != 0});
                repeat (3) step(1'b0, 8'h10, '0, 1'b1);
                check_all("R4 hold");
                step(1'b1, 8'h14, 32'h0000_0000, 1'b0);
                check_all("R6");
                chk("R6 irq low", {31'd0, irq}, 32'd0);
            end
        end

        // R2: wrap case, match below captured counter
        step(1'b1, 8'h1C, 32'd1, 1'b0);
        b = m_base;
        step(1'b1, 8'h00, b - 32'd3, 1'b0);
        rd(8'h10, v); chk("R2 wrap", v, b + 32'd1);
        repeat (5) step(1'b0, 8'h00, '0, 1'b1);
        rd(8'h10, v); chk("R2 wrap ticks", v, b + 32'd6);
        check_all("R2");
        step(1'b1, 8'h00, b + 32'd4, 1'b0);
        rd(8'h10, v); chk("R2 rearm base", v, b);
        run_out(1, "R2");
        rd(8'h10, v); chk("R4 after wrap", v, b + 32'd4);
        step(1'b1, 8'h14, 32'hFFFF_FFFF, 1'b0);
        check_all("R6 any data");

        // R9: match write collides with the expiring tick
        b = m_base;
        step(1'b1, 8'h00, b + 32'd2, 1'b0);
        step(1'b0, 8'h00, '0, 1'b1);
        step(1'b1, 8'h00, b + 32'd5, 1'b1);
        check_all("R9");
        chk("R9 no irq", {31'd0, irq}, 32'd0);
        rd(8'h10, v); chk("R9 rearm", v, b);
        run_out(2, "R9");
        chk("R9 later irq", {31'd0, irq}, 32'd1);
        step(1'b1, 8'h14, 32'd0, 1'b0);

        // R8: unmapped addresses
        step(1'b1, 8'h1C, 32'h0000_0F0F, 1'b0);
        for (int a = 0; a < 64; a += 4) begin
            if (a != 8'h00 && a != 8'h10 && a != 8'h14 && a != 8'h1C) begin
                step(1'b1, 8'(a), 32'hDEAD_BEEF, 1'b1);
                rd(8'(a), v); chk("R8 unmapped read", v, 32'd0);
                check_all("R8");
            end
        end
        rd(8'h00, v); chk("R8 match read", v, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule